// File: doc/BRIEF.md
# Pulse-Width Leaky Integrate-and-Fire Neuron

This block is a single clocked spiking neuron. An incoming spike carries a 7-bit weight and a polarity flag. A synapse stage converts the weight into a pulse that stays high for exactly that many clock cycles. While the pulse is high, a membrane counter steps up by one each cycle for an excitatory input, or down by one each cycle for an inhibitory input. The weight is therefore integrated over time, one unit per cycle, rather than added in a single step.

When no pulse is present and leakage is enabled, the membrane loses one unit every leak period, and it never goes below zero. A comparator looks at the membrane only in cycles where it is incremented. When the new value is above the threshold, the neuron emits a one-cycle output spike and the membrane returns to zero at the same clock edge.

The input is a valid/ready stream:
- A spike transfers on a clock edge where `spk_valid` and `spk_ready` are both high.
- `spk_ready` is low for the whole time a pulse is being integrated.
- A spike offered while `spk_ready` is low is not taken, and it leaves no trace.
- A source that must not lose spikes holds `spk_valid` until `spk_ready` returns.

The output spike is a plain pulse with no back-pressure.

Top module: `lif_neuron`

## Requirements
- R1: After reset, `potential` is 0, `fire_out` is low and `spk_ready` is high.
- R2: An accepted spike of weight W gives a pulse of exactly W cycles, starting on the edge after acceptance. `spk_ready` is low during those cycles and high again after the W-th pulse edge. A weight of 0 leaves the potential unchanged.
- R3: A spike offered while `spk_ready` is low is ignored. The pulse in progress keeps its length and its polarity.
- R4: With `spk_inhib` = 0 (excitatory), `potential` rises by one at every pulse edge. It saturates at 255 and does not wrap.
- R5: With `spk_inhib` = 1 (inhibitory), `potential` falls by one at every pulse edge. It holds at 0 and never goes below it.
- R6: When an increment yields a value strictly greater than `threshold`, two things happen at that edge: `potential` becomes 0, and `fire_out` is high for exactly one cycle after it. Starting from 0, W excitatory units therefore produce W/(threshold+1) spikes (integer division) and leave W mod (threshold+1).
- R7: The threshold is evaluated only on increment cycles. Inhibitory steps and leak steps never fire, even when `potential` is above `threshold`.
- R8: With `leak_en` = 1 and no pulse, `potential` drops by one on every P-th idle edge, where P = `leak_period`; a value of 0 acts as 1. The potential stops at 0. With `leak_en` = 0, it holds while idle.
- R9: The leak-period count restarts from zero while a pulse is active, and on a fire. After a pulse, the first leak step comes P idle edges after the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| spk_valid | input | 1 | Input spike offered |
| spk_ready | output | 1 | Synapse idle, spike can be taken |
| spk_weight | input | 7 | Weight of the offered spike |
| spk_inhib | input | 1 | Polarity of the offered spike: 1 = inhibitory |
| leak_en | input | 1 | Enables the idle-time leak |
| leak_period | input | 8 | Idle cycles per leak step (0 acts as 1) |
| threshold | input | 8 | Firing threshold, 1 to 255 |
| fire_out | output | 1 | One-cycle output spike |
| potential | output | 8 | Present membrane value |

## Verification
The assertions assume that reset is applied before any stimulus. They also assume that `leak_period`, `leak_en` and `threshold` change only in cycles with no pulse in progress. The checks on the leak step and on firing only on increments depend on that. The bench keeps to this by changing configuration only after an injection has fully completed. In one case it lowers the threshold while the membrane stands above it, between injections. It keeps `threshold` in the range 1 to 255, since an increment-only comparison with a threshold of 0 would fire at the first step.

// File: rtl/lif_pkg.sv
package lif_pkg;
  typedef enum logic {
    POL_EXCITE  = 1'b0,
    POL_INHIBIT = 1'b1
  } polarity_e;
endpackage

// File: rtl/lif_synapse.sv
module lif_synapse
  import lif_pkg::*;
#(
  parameter int WEIGHT_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WEIGHT_W-1:0] in_weight,
  input  polarity_e           in_pol,
  output logic                pulse,
  output polarity_e           pulse_pol
);
  logic [WEIGHT_W-1:0] remain_q;
  polarity_e           pol_q;

  assign in_ready  = (remain_q == '0);
  assign pulse     = !in_ready;
  assign pulse_pol = pol_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
      pol_q    <= POL_EXCITE;
    end else if (in_valid && in_ready) begin
      remain_q <= in_weight;
      pol_q    <= in_pol;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  // R2: a nonzero accepted weight raises the pulse on the next edge
  a_r2_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_weight != '0) |=> pulse);

  // R3: an offer while busy does not reload the countdown
  a_r3_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (remain_q == $past(remain_q) - 1'b1));

  // R3: polarity is steady across a running pulse
  a_r3_pol_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && $past(pulse)) |-> $stable(pulse_pol));
endmodule

// File: rtl/lif_core.sv
module lif_core
  import lif_pkg::*;
#(
  parameter int POT_W  = 8,
  parameter int LEAK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse,
  input  polarity_e         pulse_pol,
  input  logic              leak_en,
  input  logic [LEAK_W-1:0] leak_period,
  input  logic              fire,
  output logic              inc_step,
  output logic [POT_W-1:0]  inc_value,
  output logic [POT_W-1:0]  pot
);
  localparam logic [POT_W-1:0] POT_MAX = {POT_W{1'b1}};

  logic [POT_W-1:0]  pot_q;
  logic [LEAK_W-1:0] lk_q;
  logic [LEAK_W:0]   lk_plus;
  logic              dec_step;
  logic              leak_tick;

  assign inc_step  = pulse && (pulse_pol == POL_EXCITE) && (pot_q != POT_MAX);
  assign dec_step  = pulse && (pulse_pol == POL_INHIBIT) && (pot_q != '0);
  assign inc_value = pot_q + 1'b1;
  assign lk_plus   = {1'b0, lk_q} + 1'b1;
  assign leak_tick = !pulse && leak_en && (lk_plus >= {1'b0, leak_period});
  assign pot       = pot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_q <= '0;
    end else if (pulse || fire || !leak_en || leak_tick) begin
      lk_q <= '0;
    end else begin
      lk_q <= lk_plus[LEAK_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pot_q <= '0;
    end else if (fire) begin
      pot_q <= '0;
    end else if (inc_step) begin
      pot_q <= inc_value;
    end else if (dec_step) begin
      pot_q <= pot_q - 1'b1;
    end else if (leak_tick && pot_q != '0) begin
      pot_q <= pot_q - 1'b1;
    end
  end

  // R4: excitatory step raises by one, holds at the ceiling
  a_r4_inc_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && pulse_pol == POL_EXCITE && !fire) |=>
      (pot_q == (($past(pot_q) == POT_MAX) ? POT_MAX : $past(pot_q) + 1'b1)));

  // R5: inhibitory step lowers by one, floors at zero
  a_r5_dec_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && pulse_pol == POL_INHIBIT) |=>
      (pot_q == (($past(pot_q) == '0) ? '0 : $past(pot_q) - 1'b1)));

  // R6: a fire returns the membrane to rest
  a_r6_rest: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (pot_q == '0));

  // R8: idle with leak off holds the potential
  a_r8_leak_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse && !leak_en) |=> $stable(pot_q));

  // R8: idle leak moves by at most one
  a_r8_leak_step: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse |=> (pot_q == $past(pot_q) || pot_q == $past(pot_q) - 1'b1));

  // R9: period count restarts during a pulse
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> (lk_q == '0));
endmodule

// File: rtl/lif_threshold.sv
module lif_threshold #(
  parameter int POT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_step,
  input  logic [POT_W-1:0] inc_value,
  input  logic [POT_W-1:0] threshold,
  output logic             fire,
  output logic             spike_q
);
  assign fire = inc_step && (inc_value > threshold);

  always_ff @(posedge clk) begin
    if (!rst_n) spike_q <= 1'b0;
    else        spike_q <= fire;
  end

  // R6: output spike never lasts two cycles
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    spike_q |=> !spike_q);

  // R7: no increment, no spike
  a_r7_inc_only: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_step |=> !spike_q);
endmodule

// File: rtl/lif_neuron.sv
module lif_neuron
  import lif_pkg::*;
#(
  parameter int WEIGHT_W = 7,
  parameter int POT_W    = 8,
  parameter int LEAK_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spk_valid,
  output logic                spk_ready,
  input  logic [WEIGHT_W-1:0] spk_weight,
  input  logic                spk_inhib,
  input  logic                leak_en,
  input  logic [LEAK_W-1:0]   leak_period,
  input  logic [POT_W-1:0]    threshold,
  output logic                fire_out,
  output logic [POT_W-1:0]    potential
);
  logic             pulse;
  polarity_e        pulse_pol;
  polarity_e        in_pol;
  logic             inc_step;
  logic [POT_W-1:0] inc_value;
  logic             fire;

  assign in_pol = spk_inhib ? POL_INHIBIT : POL_EXCITE;

  lif_synapse #(.WEIGHT_W(WEIGHT_W)) u_syn (
    .clk(clk), .rst_n(rst_n),
    .in_valid(spk_valid), .in_ready(spk_ready),
    .in_weight(spk_weight), .in_pol(in_pol),
    .pulse(pulse), .pulse_pol(pulse_pol)
  );

  lif_core #(.POT_W(POT_W), .LEAK_W(LEAK_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .pulse(pulse), .pulse_pol(pulse_pol),
    .leak_en(leak_en), .leak_period(leak_period),
    .fire(fire), .inc_step(inc_step), .inc_value(inc_value),
    .pot(potential)
  );

  lif_threshold #(.POT_W(POT_W)) u_thr (
    .clk(clk), .rst_n(rst_n),
    .inc_step(inc_step), .inc_value(inc_value),
    .threshold(threshold), .fire(fire), .spike_q(fire_out)
  );

  // R1: idle after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (spk_ready && !fire_out && potential == '0));
endmodule

// File: tb/lif_neuron_bench.sv
module lif_neuron_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spk_valid = 1'b0;
  logic       spk_ready;
  logic [6:0] spk_weight = '0;
  logic       spk_inhib = 1'b0;
  logic       leak_en = 1'b0;
  logic [7:0] leak_period = 8'd1;
  logic [7:0] threshold = 8'd255;
  logic       fire_out;
  logic [7:0] potential;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  lif_neuron u_lif_neuron (
    .clk(clk), .rst_n(rst_n), .spk_valid(spk_valid), .spk_ready(spk_ready),
    .spk_weight(spk_weight), .spk_inhib(spk_inhib), .leak_en(leak_en),
    .leak_period(leak_period), .threshold(threshold),
    .fire_out(fire_out), .potential(potential)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Offer one spike, follow its w pulse edges, count output spikes.
  task automatic inject(input int w, input bit inh, output int spikes);
    bit prev;
    spikes = 0;
    prev = 0;
    @(negedge clk);
    spk_valid = 1'b1; spk_weight = 7'(w); spk_inhib = inh;
    @(negedge clk);
    spk_valid = 1'b0;
    chk(spk_ready == (w == 0), "R2 ready after accept", spk_ready, w == 0);
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (fire_out) spikes++;
      chk(!(prev && fire_out), "R6 spike width", 2, 1);
      prev = fire_out;
    end
    chk(spk_ready == 1'b1, "R2 ready after pulse", spk_ready, 1);
  endtask

  task automatic clear_to_zero(input int cur);
    int s;
    while (cur > 0) begin
      inject((cur > 127) ? 127 : cur, 1'b1, s);
      cur = (cur > 127) ? cur - 127 : 0;
    end
    chk(potential == 0, "R5 cleared", potential, 0);
  endtask

  task automatic set_pot(input int v);
    int s;
    threshold = 8'd255;
    while (v > 0) begin
      inject((v > 127) ? 127 : v, 1'b0, s);
      v = (v > 127) ? v - 127 : 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; vectors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int s, exp_pot, exp_sp, pe;
    int thr_list[5] = '{1, 6, 37, 126, 200};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(potential == 0, "R1 potential", potential, 0);
    chk(fire_out == 0, "R1 fire", fire_out, 0);
    chk(spk_ready == 1, "R1 ready", spk_ready, 1);

    // R2: zero weight is a no-op
    inject(0, 1'b0, s);
    chk(potential == 0, "R2 zero weight", potential, 0);

    // R6/R4: threshold sweep from rest
    foreach (thr_list[t]) begin
      int step = (t == 0 || t == 2) ? 1 : 5;
      for (int w = 0; w < 128; w += step) begin
        threshold = 8'(thr_list[t]);
        inject(w, 1'b0, s);
        exp_sp  = w / (thr_list[t] + 1);
        exp_pot = w % (thr_list[t] + 1);
        chk(s == exp_sp, "R6 spike count", s, exp_sp);
        chk(potential == exp_pot, "R6 residue", potential, exp_pot);
        clear_to_zero(exp_pot);
      end
    end

    // R5: inhibitory floor sweep
    foreach (thr_list[i]) begin
      for (int w = 0; w < 128; w += 21) begin
        int p = (i * 31) % 128;
        set_pot(p);
        inject(w, 1'b1, s);
        exp_pot = (p > w) ? p - w : 0;
        chk(potential == exp_pot, "R5 inhibit floor", potential, exp_pot);
        chk(s == 0, "R7 no fire on decrement", s, 0);
        clear_to_zero(exp_pot);
      end
    end

    // R4: saturation at 255
    set_pot(254);
    inject(127, 1'b0, s);
    chk(potential == 255, "R4 saturate", potential, 255);
    chk(s == 0, "R4 no spike at ceiling", s, 0);
    clear_to_zero(255);

    // R7: threshold lowered under a high membrane
    set_pot(100);
    threshold = 8'd10;
    inject(5, 1'b1, s);
    chk(potential == 95, "R7 dec above threshold", potential, 95);
    chk(s == 0, "R7 no fire on dec", s, 0);
    inject(1, 1'b0, s);
    chk(s == 1, "R7 fire on increment", s, 1);
    chk(potential == 0, "R6 reset to rest", potential, 0);
    threshold = 8'd255;

    // R3: offers during a pulse are dropped
    @(negedge clk);
    spk_valid = 1'b1; spk_weight = 7'd10; spk_inhib = 1'b0;
    @(negedge clk);
    spk_weight = 7'd50; spk_inhib = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(spk_ready == 0, "R3 ready low while busy", spk_ready, 0);
    end
    spk_valid = 1'b0;
    repeat (7) @(negedge clk);
    chk(potential == 10, "R3 pulse unchanged", potential, 10);
    repeat (5) @(negedge clk);
    chk(potential == 10, "R3 no extra pulse", potential, 10);
    clear_to_zero(10);

    // R8: leak sweep
    for (int p = 0; p < 8; p += 1) begin
      foreach (thr_list[v]) begin
        int val = 3 + v * 9;
        set_pot(val);
        @(negedge clk);
        leak_period = 8'(p); leak_en = 1'b1;
        repeat (20) @(negedge clk);
        pe = (p == 0) ? 1 : p;
        exp_pot = (val > 20 / pe) ? val - 20 / pe : 0;
        chk(potential == exp_pot, "R8 leak decay", potential, exp_pot);
        leak_en = 1'b0;
        repeat (10) @(negedge clk);
        chk(potential == exp_pot, "R8 leak off holds", potential, exp_pot);
        clear_to_zero(exp_pot);
      end
    end

    // R9: leak count restarts after a pulse
    set_pot(10);
    @(negedge clk);
    leak_period = 8'd4; leak_en = 1'b1;
    @(negedge clk);
    inject(2, 1'b0, s);
    chk(potential == 12, "R9 pre-leak", potential, 12);
    repeat (3) @(negedge clk);
    chk(potential == 12, "R9 restart holds", potential, 12);
    @(negedge clk);
    chk(potential == 11, "R9 first leak step", potential, 11);
    leak_en = 1'b0;

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule